// File: doc/BRIEF.md
# Shared Parameter RAM Access Arbiter

This block arbitrates a single-port parameter RAM between two microengines and a host side made up of a host bus port and a coherent dual-parameter transfer controller. Time is cut into one-clock slots that alternate between engine 0 and engine 1. In each slot only the slot's engine, the host or the transfer controller may reach the RAM, and the arbiter picks one of them.

The arbiter keeps two consecutive accesses from one engine together, so that the host side cannot get in between them. The two engines may still interleave with each other. Priority changes from slot to slot. It depends on who used the engine's previous slot, on whether the engine is in the middle of a pair, on whether a transfer has already started, and on whether the host side lost the slot just before. The arbiter drives one-hot grants and the select for the RAM address/data mux. It also shows each engine's pair phase.

Top module: `param_ram_arbiter`

## Requirements
- R1: Grants are one-hot or all zero. `ram_en` is high exactly when a grant is given. `ram_sel` encodes the winner: 0 = engine 0, 1 = engine 1, 2 = host, 3 = transfer controller.
- R2: `slot_owner` is 0 in the first cycle after reset and then toggles every cycle. An engine is granted only in its own slot.
- R3: An engine request that is the second access of a pair (phase 1, no thread start) always wins its slot.
- R4: After an engine completes the second access of a pair, the next slot of that engine goes to the host side if it is requesting.
- R5: If nobody accessed the RAM in an engine's previous slot, a host-side request wins that engine's next slot.
- R6: If the host side accessed the RAM in an engine's previous slot, the engine's request wins the next slot. This does not apply when the host side lost the immediately preceding cycle, or when a transfer is in progress.
- R7: While `xfer_busy` is high, a transfer request beats the engine in every case except a pair's second access. Within the host side, a busy transfer beats the host. Otherwise the host beats the transfer controller.
- R8: Engine accesses pair strictly in twos. A granted access flips the engine's `pair_phase`, so the third access is again a first.
- R9: An access marked with `eng_tstart` always counts as a first access and leaves `pair_phase` at 1. A thread start that is not granted returns `pair_phase` to 0.
- R10: A host-side request that loses a cycle wins the next one unless that cycle is a pair's second access. No host-side request loses more than 3 consecutive cycles.
- R11: During and right after reset there are no grants, both `pair_phase` bits are 0 and `slot_owner` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_req | input | 2 | RAM request per engine |
| eng_tstart | input | 2 | Per engine: current access is the first preload of a new thread |
| host_req | input | 1 | Host bus port request |
| xfer_req | input | 1 | Transfer controller request |
| xfer_busy | input | 1 | Transfer controller is past the first read of a transfer |
| gnt_eng | output | 2 | Per-engine grant |
| gnt_host | output | 1 | Host grant |
| gnt_xfer | output | 1 | Transfer controller grant |
| ram_en | output | 1 | A RAM access takes place this cycle |
| ram_sel | output | 2 | RAM address/data mux select |
| slot_owner | output | 1 | Engine owning the current slot |
| pair_phase | output | 2 | Per engine: 1 when the next access is the second of a pair |

## Verification
Four stimulus mixes run against a cycle model in the bench. The light mix leaves many slots unused and so exercises idle-slot host priority (R5). The dense mix keeps every requester busy and separates pair protection (R3) from the return of priority after a pair (R4, R6) and from the starvation bound (R10). The transfer-heavy mix holds `xfer_busy` high and shows that only a pair's second access beats a running transfer (R7). The thread-start mix drives frequent `eng_tstart` and shows that pairing restarts and is never carried across threads (R8, R9).

// File: rtl/param_ram_arbiter.sv
module param_ram_arbiter #(
  parameter int MAX_WAIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] eng_req,
  input  logic [1:0] eng_tstart,
  input  logic       host_req,
  input  logic       xfer_req,
  input  logic       xfer_busy,
  output logic [1:0] gnt_eng,
  output logic       gnt_host,
  output logic       gnt_xfer,
  output logic       ram_en,
  output logic [1:0] ram_sel,
  output logic       slot_owner,
  output logic [1:0] pair_phase
);

  logic       slot;
  logic [1:0] phase, done_pair, idle_last;
  logic       hs_lost;
  logic       eng_win, hs_win;

  wire er       = eng_req[slot];
  wire ts       = eng_tstart[slot];
  wire second   = er & phase[slot] & ~ts;
  wire hs_req   = host_req | xfer_req;
  wire xfer_hot = xfer_req & xfer_busy;
  wire hs_first = hs_req & (done_pair[slot] | idle_last[slot] | hs_lost);
  wire pick_x   = xfer_hot | ~host_req;

  always_comb begin
    eng_win = 1'b0;
    hs_win  = 1'b0;
    if (!rst) begin
      if (second)        eng_win = 1'b1;
      else if (xfer_hot) hs_win  = 1'b1;
      else if (hs_first) hs_win  = 1'b1;
      else if (er)       eng_win = 1'b1;
      else if (hs_req)   hs_win  = 1'b1;
    end
  end

  assign gnt_eng    = eng_win ? (slot ? 2'b10 : 2'b01) : 2'b00;
  assign gnt_host   = hs_win & ~pick_x;
  assign gnt_xfer   = hs_win & pick_x;
  assign ram_en     = eng_win | hs_win;
  assign ram_sel    = eng_win ? {1'b0, slot} : (hs_win ? {1'b1, pick_x} : 2'b00);
  assign slot_owner = slot;
  assign pair_phase = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= 1'b0;
      phase     <= 2'b00;
      done_pair <= 2'b00;
      idle_last <= 2'b11;
      hs_lost   <= 1'b0;
    end else begin
      slot            <= ~slot;
      hs_lost         <= hs_req & ~hs_win;
      done_pair[slot] <= eng_win & phase[slot] & ~ts;
      idle_last[slot] <= ~(eng_win | hs_win);
      if (eng_win)  phase[slot] <= ts ? 1'b1 : ~phase[slot];
      else if (ts)  phase[slot] <= 1'b0;
    end
  end

  logic [2:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (rst) wait_cnt <= '0;
    else if (hs_req && !hs_win) wait_cnt <= wait_cnt + 3'd1;
    else wait_cnt <= '0;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_eng, gnt_host, gnt_xfer}) && (ram_en == ($countones({gnt_eng, gnt_host, gnt_xfer}) == 1)));

  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_owner != $past(slot_owner));

  a_r2_own_slot: assert property (@(posedge clk) disable iff (rst)
    gnt_eng[~slot_owner] == 1'b0);

  a_r3_second_wins: assert property (@(posedge clk) disable iff (rst)
    (eng_req[slot_owner] && pair_phase[slot_owner] && !eng_tstart[slot_owner]) |-> gnt_eng[slot_owner]);

  a_r8_phase_flip0: assert property (@(posedge clk) disable iff (rst)
    (gnt_eng[0] && !eng_tstart[0]) |=> pair_phase[0] != $past(pair_phase[0]));

  a_r9_tstart_first: assert property (@(posedge clk) disable iff (rst)
    (gnt_eng[1] && eng_tstart[1]) |=> pair_phase[1]);

  a_r10_bounded_wait: assert property (@(posedge clk) disable iff (rst)
    ((host_req || xfer_req) && !gnt_host && !gnt_xfer) |-> wait_cnt < 3'(MAX_WAIT));

endmodule

// File: tb/param_ram_arbiter_test.sv
module param_ram_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] eng_req = '0, eng_tstart = '0;
  logic host_req = 1'b0, xfer_req = 1'b0, xfer_busy = 1'b0;
  logic [1:0] gnt_eng, ram_sel, pair_phase;
  logic gnt_host, gnt_xfer, ram_en, slot_owner;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  param_ram_arbiter uut (
    .clk(clk), .rst(rst), .eng_req(eng_req), .eng_tstart(eng_tstart),
    .host_req(host_req), .xfer_req(xfer_req), .xfer_busy(xfer_busy),
    .gnt_eng(gnt_eng), .gnt_host(gnt_host), .gnt_xfer(gnt_xfer),
    .ram_en(ram_en), .ram_sel(ram_sel), .slot_owner(slot_owner), .pair_phase(pair_phase));

  bit m_slot;
  bit [1:0] m_ph, m_done, m_idle;
  bit m_lost;
  int m_wait;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_slot = 0; m_ph = 0; m_done = 0; m_idle = 2'b11; m_lost = 0; m_wait = 0;
  endtask

  // winner code: 0 none, 1 engine of slot, 2 host, 3 transfer
  task automatic step(input bit [1:0] er, input bit [1:0] ts, input bit h, input bit x, input bit b);
    int win;
    string why;
    bit e, hs, pair2;
    int exp_sel, act_sel;
    @(negedge clk);
    eng_req = er; eng_tstart = ts; host_req = h; xfer_req = x; xfer_busy = b;
    #2;
    e = m_slot;
    hs = h | x;
    pair2 = er[e] && m_ph[e] && !ts[e];
    win = 0; why = "R1";
    if (pair2) begin win = 1; why = "R3"; end
    else if (x && b) begin win = 3; why = "R7"; end
    else if (hs && m_lost) begin win = h ? 2 : 3; why = "R10"; end
    else if (hs && m_done[e]) begin win = h ? 2 : 3; why = "R4"; end
    else if (hs && m_idle[e]) begin win = h ? 2 : 3; why = "R5"; end
    else if (er[e]) begin win = 1; why = "R6"; end
    else if (hs) begin win = h ? 2 : 3; why = "R7"; end
    exp_sel = (win == 1) ? int'(e) : (win >= 2 ? win : 0);
    act_sel = ram_en ? int'(ram_sel) : 0;
    check(slot_owner == e, "R2", slot_owner, e);
    check(ram_en == (win != 0) && $countones({gnt_eng, gnt_host, gnt_xfer}) == (win != 0 ? 1 : 0),
          "R1", ram_en, win != 0);
    check(act_sel == exp_sel && gnt_eng[e] == (win == 1) && gnt_eng[~e] == 1'b0 &&
          gnt_host == (win == 2) && gnt_xfer == (win == 3), why, act_sel, exp_sel);
    check(pair_phase == m_ph, ts != 0 ? "R9" : "R8", pair_phase, m_ph);
    if (hs && win < 2) m_wait++; else m_wait = 0;
    check(m_wait <= 3, "R10", m_wait, 3);
    m_lost = hs && win < 2;
    m_done[e] = (win == 1) && m_ph[e] && !ts[e];
    m_idle[e] = (win == 0);
    if (win == 1) m_ph[e] = ts[e] ? 1'b1 : ~m_ph[e];
    else if (ts[e]) m_ph[e] = 1'b0;
    m_slot = ~m_slot;
  endtask

  function automatic logic [15:0] nx(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    model_reset();
    repeat (3) @(negedge clk);
    #2;
    check(ram_en == 0 && gnt_eng == 0 && !gnt_host && !gnt_xfer, "R11", ram_en, 0);
    check(pair_phase == 0 && slot_owner == 0, "R11", {pair_phase, slot_owner}, 0);
    eng_req = 2'b11; host_req = 1'b1;
    #1;
    check(ram_en == 0, "R11", ram_en, 0);
    @(negedge clk); rst = 1'b0; eng_req = 0; host_req = 0;
    #2;
    check(slot_owner == 0 && pair_phase == 0, "R11", slot_owner, 0);
    @(posedge clk);
    model_reset();
    m_slot = 1;

    // directed: engine 0 pair against a waiting host, then a third access
    step(2'b00, 2'b00, 0, 0, 0);
    step(2'b01, 2'b00, 1, 0, 0);
    step(2'b00, 2'b00, 1, 0, 0);
    step(2'b01, 2'b00, 1, 0, 0);
    step(2'b00, 2'b00, 0, 0, 0);
    step(2'b01, 2'b00, 1, 0, 0);
    step(2'b00, 2'b00, 0, 0, 0);
    step(2'b01, 2'b01, 0, 0, 0);

    for (int mix = 0; mix < 4; mix++) begin
      for (int n = 0; n < 3000; n++) begin
        bit [1:0] er, ts;
        bit h, x, b;
        lfsr = nx(nx(nx(lfsr)));
        r = lfsr;
        case (mix)
          0: begin er = r[1:0] & r[3:2]; h = r[4] & r[5]; x = r[6] & r[7] & r[8]; b = x & r[9]; ts = 0; end
          1: begin er = r[1:0] | r[3:2]; h = r[4] | r[5]; x = r[6]; b = x & r[7] & r[8]; ts = 0; end
          2: begin er = r[1:0]; h = r[4]; x = r[6] | r[7]; b = x & (r[8] | r[9]); ts = er & {r[10] & r[11], r[12] & r[13]}; end
          default: begin er = r[1:0] | r[3:2]; h = r[4]; x = r[6]; b = x & r[7]; ts = {r[10], r[12]}; end
        endcase
        step(er, ts, h, x, b);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule